// File: doc/BRIEF.md
# Received Frame Area Writer

This block builds the status frames that a serial storage host port leaves for software in its received-frame memory area. Two frame kinds exist. One is a 32-byte register frame that reports the device's status and error bytes and echoes part of the command that triggered it. The other is an 8-byte completion frame that reports finished queued tags. Each frame goes out one byte per cycle through a plain byte-wide memory write port, at a fixed offset from the area base address. After the last byte, the block pulses the interrupt-status bits that belong to that frame kind toward the port's register block.

The block also owns the completion-tag accumulator. Finished tags collect here until software reads the active-tag register. On that read the collected set is handed back so that the register block can drop those bits from its active set, and the accumulator is emptied.

Top module: `rfis_writer`

## Requirements
- R1: When `rx_enable` or `area_valid` is low in the request cycle, a request of either kind writes no byte, raises no interrupt and leaves `done_tags` unchanged.
- R2: A register frame writes byte 0 = 0x34, byte 1 = 0x40 if `glob_irq_pend` was high at request time and 0x00 otherwise, byte 2 = status and byte 3 = error. Byte i goes to address base + 0x40 + i.
- R3: Register frame bytes 4 to 13 copy command bytes 4 to 13. Command byte k sits at `cmd_bytes[8*(k-4)+7 : 8*(k-4)]`. Bytes 14 to 31 are written as zero.
- R4: One cycle after the last byte of a register frame, `irq_d2h` pulses for one cycle. `irq_tfe` pulses in the same cycle exactly when status bit 0 was set.
- R5: A completion frame writes to base + 0x58 + i. Byte 0 = error, byte 1 = 0, byte 2 = status AND 0x77, byte 3 = 0, and bytes 4 to 7 = the accumulated tag mask, least significant byte first. One cycle after its last byte, `irq_sdb` pulses alone.
- R6: The tag mask starts empty after reset. Each accepted completion request ORs `sdb_tags` into it, and the frame reports the mask as it stands when the frame starts.
- R7: While `sact_read` is high, `done_tags` shows the current mask; the next cycle it is empty. Tags requested in that same cycle remain in the mask.
- R8: When `d2h_init` is set, the echoed command image is all zero except bytes 4 and 12, which are 0x01. If `atapi_dev` is also set, bytes 5 and 6 are 0x14 and 0xEB.
- R9: Frames never interleave. When both kinds are waiting, the register frame goes first. A completion request made during a register frame is written after it.
- R10: Within a frame, bytes go out in ascending address order, one per cycle, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Frame reception enabled by software |
| area_valid | input | 1 | Received-frame base address has been programmed |
| area_base | input | ADDR_W | Base address of the received-frame area |
| tf_status | input | 8 | Current device status byte |
| tf_error | input | 8 | Current device error byte |
| glob_irq_pend | input | 1 | Global interrupt status is nonzero |
| d2h_req | input | 1 | Request a register frame |
| d2h_init | input | 1 | Use the power-on command image instead of `cmd_bytes` |
| atapi_dev | input | 1 | Attached device is packet-command type |
| cmd_bytes | input | 80 | Command frame bytes 4 to 13 |
| sdb_req | input | 1 | Request a completion frame |
| sdb_tags | input | TAG_N | Newly finished tags |
| sact_read | input | 1 | Software reads the active-tag register |
| done_tags | output | TAG_N | Accumulated finished tags |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq_d2h | output | 1 | Register-frame interrupt pulse |
| irq_tfe | output | 1 | Task-file-error interrupt pulse |
| irq_sdb | output | 1 | Completion-frame interrupt pulse |

## Verification
Register frames are driven with distinct command patterns and with status bytes that have bit 0 clear and set. This separates a wrong byte offset from a wrong error-interrupt decision and from a stale command image. The power-on image is tried both with and without the packet-device flag. Completion frames are sent with status bits that the 0x77 mask must strip, with tags that spread over all four mask bytes, and with a software read that lands in the same cycle as a new completion. Simultaneous and overlapping requests, a base address change, and requests with reception disabled or no base set show the ordering rule and the gating.

// File: rtl/rfis_pkg.sv
package rfis_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_D2H  = 2'd1,
      ST_SDB  = 2'd2,
      ST_IRQ  = 2'd3
   } rfis_state_e;

   localparam logic [7:0] D2H_TYPE_CODE = 8'h34;
   localparam logic [7:0] SDB_STAT_KEEP = 8'h77;
   localparam logic [7:0] PKT_SIG_MID   = 8'h14;
   localparam logic [7:0] PKT_SIG_HIGH  = 8'hEB;
   localparam int         CMD_ECHO_N    = 10;
   localparam int         CMD_ECHO_W    = 8 * CMD_ECHO_N;

endpackage

// File: rtl/rfis_done_mask.sv
module rfis_done_mask #(
   parameter int TAG_N = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [TAG_N-1:0] add_tags,
   input  logic             clr,
   output logic [TAG_N-1:0] mask
);

   logic [TAG_N-1:0] mask_q;
   logic [TAG_N-1:0] mask_d;

   always_comb begin
      mask_d = clr ? '0 : mask_q;
      if (add_en) mask_d = mask_d | add_tags;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign mask = mask_q;

endmodule

// File: rtl/rfis_frame_gen.sv
module rfis_frame_gen
   import rfis_pkg::*;
#(
   parameter int TAG_N = 32,
   parameter int IDX_W = 5
) (
   input  logic                  is_sdb,
   input  logic [IDX_W-1:0]      idx,
   input  logic [7:0]            st,
   input  logic [7:0]            er,
   input  logic                  gflag,
   input  logic [CMD_ECHO_W-1:0] cmd,
   input  logic [TAG_N-1:0]      tags,
   output logic [7:0]            data
);

   logic [31:0] tags32;

   generate
      if (TAG_N < 32) begin : g_pad
         assign tags32 = {{(32 - TAG_N){1'b0}}, tags};
      end else begin : g_full
         assign tags32 = tags;
      end
   endgenerate

   logic [7:0] d2h_b;
   logic [7:0] sdb_b;

   always_comb begin
      d2h_b = 8'h00;
      if (idx == IDX_W'(0)) d2h_b = D2H_TYPE_CODE;
      if (idx == IDX_W'(1)) d2h_b = {1'b0, gflag, 6'b0};
      if (idx == IDX_W'(2)) d2h_b = st;
      if (idx == IDX_W'(3)) d2h_b = er;
      for (int k = 0; k < CMD_ECHO_N; k++) begin
         if (idx == IDX_W'(k + 4)) d2h_b = cmd[8*k +: 8];
      end
   end

   always_comb begin
      sdb_b = 8'h00;
      if (idx == IDX_W'(0)) sdb_b = er;
      if (idx == IDX_W'(2)) sdb_b = st & SDB_STAT_KEEP;
      for (int k = 0; k < 4; k++) begin
         if (idx == IDX_W'(k + 4)) sdb_b = tags32[8*k +: 8];
      end
   end

   assign data = is_sdb ? sdb_b : d2h_b;

endmodule

// File: rtl/rfis_seq.sv
module rfis_seq
   import rfis_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int          TAG_N   = 32,
   parameter int          D2H_LEN = 32,
   parameter int          SDB_LEN = 8,
   parameter int          D2H_OFS = 'h40,
   parameter int          SDB_OFS = 'h58,
   parameter int          IDX_W   = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  gate,
   input  logic                  d2h_req,
   input  logic                  d2h_init,
   input  logic                  atapi,
   input  logic [CMD_ECHO_W-1:0] cmd_img,
   input  logic [7:0]            st_in,
   input  logic [7:0]            er_in,
   input  logic                  gpend,
   input  logic                  sdb_req,
   input  logic [ADDR_W-1:0]     base_in,
   input  logic [TAG_N-1:0]      mask_now,
   output logic                  a_sdb,
   output logic [IDX_W-1:0]      idx,
   output logic [7:0]            a_st,
   output logic [7:0]            a_er,
   output logic                  a_g,
   output logic [CMD_ECHO_W-1:0] a_cmd,
   output logic [TAG_N-1:0]      a_tags,
   output logic                  we,
   output logic [ADDR_W-1:0]     addr,
   output logic                  p_d2h,
   output logic                  p_tfe,
   output logic                  p_sdb
);

   rfis_state_e state;

   // waiting slot, register frame
   logic                  wd_pend;
   logic [7:0]            wd_st, wd_er;
   logic                  wd_g;
   logic [CMD_ECHO_W-1:0] wd_cmd;
   logic [ADDR_W-1:0]     wd_base;
   // waiting slot, completion frame
   logic                  ws_pend;
   logic [7:0]            ws_st, ws_er;
   logic [ADDR_W-1:0]     ws_base;
   // active frame
   logic [ADDR_W-1:0]     a_base;

   logic [CMD_ECHO_W-1:0] init_img;
   logic                  take_d2h, take_sdb;
   logic                  start_d2h, start_sdb;
   logic                  last_d2h, last_sdb;

   always_comb begin
      init_img          = '0;
      init_img[7:0]     = 8'h01;
      init_img[71:64]   = 8'h01;
      if (atapi) begin
         init_img[15:8]  = PKT_SIG_MID;
         init_img[23:16] = PKT_SIG_HIGH;
      end
   end

   assign take_d2h  = d2h_req && gate;
   assign take_sdb  = sdb_req && gate;
   assign start_d2h = (state == ST_IDLE) && wd_pend;
   assign start_sdb = (state == ST_IDLE) && !wd_pend && ws_pend;
   assign last_d2h  = (idx == IDX_W'(D2H_LEN - 1));
   assign last_sdb  = (idx == IDX_W'(SDB_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wd_pend <= 1'b0;
         wd_st   <= '0;
         wd_er   <= '0;
         wd_g    <= 1'b0;
         wd_cmd  <= '0;
         wd_base <= '0;
      end else if (take_d2h) begin
         wd_pend <= 1'b1;
         wd_st   <= st_in;
         wd_er   <= er_in;
         wd_g    <= gpend;
         wd_cmd  <= d2h_init ? init_img : cmd_img;
         wd_base <= base_in;
      end else if (start_d2h) begin
         wd_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_pend <= 1'b0;
         ws_st   <= '0;
         ws_er   <= '0;
         ws_base <= '0;
      end else if (take_sdb) begin
         ws_pend <= 1'b1;
         ws_st   <= st_in;
         ws_er   <= er_in;
         ws_base <= base_in;
      end else if (start_sdb) begin
         ws_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         a_sdb  <= 1'b0;
         a_st   <= '0;
         a_er   <= '0;
         a_g    <= 1'b0;
         a_cmd  <= '0;
         a_tags <= '0;
         a_base <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               idx <= '0;
               if (start_d2h) begin
                  state  <= ST_D2H;
                  a_sdb  <= 1'b0;
                  a_st   <= wd_st;
                  a_er   <= wd_er;
                  a_g    <= wd_g;
                  a_cmd  <= wd_cmd;
                  a_base <= wd_base;
               end else if (start_sdb) begin
                  state  <= ST_SDB;
                  a_sdb  <= 1'b1;
                  a_st   <= ws_st;
                  a_er   <= ws_er;
                  a_g    <= 1'b0;
                  a_tags <= mask_now;
                  a_base <= ws_base;
               end
            end
            ST_D2H: begin
               if (last_d2h) state <= ST_IRQ;
               else          idx   <= idx + 1'b1;
            end
            ST_SDB: begin
               if (last_sdb) state <= ST_IRQ;
               else          idx   <= idx + 1'b1;
            end
            ST_IRQ: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [ADDR_W-1:0] ofs;
   assign ofs   = a_sdb ? ADDR_W'(SDB_OFS) : ADDR_W'(D2H_OFS);
   assign we    = (state == ST_D2H) || (state == ST_SDB);
   assign addr  = a_base + ofs + ADDR_W'(idx);
   assign p_d2h = (state == ST_IRQ) && !a_sdb;
   assign p_tfe = (state == ST_IRQ) && !a_sdb && a_st[0];
   assign p_sdb = (state == ST_IRQ) && a_sdb;

endmodule

// File: rtl/rfis_writer.sv
module rfis_writer
   import rfis_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int TAG_N   = 32,
   parameter int D2H_LEN = 32,
   parameter int SDB_LEN = 8,
   parameter int D2H_OFS = 'h40,
   parameter int SDB_OFS = 'h58,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic              area_valid,
   input  logic [ADDR_W-1:0] area_base,
   input  logic [7:0]        tf_status,
   input  logic [7:0]        tf_error,
   input  logic              glob_irq_pend,
   input  logic              d2h_req,
   input  logic              d2h_init,
   input  logic              atapi_dev,
   input  logic [79:0]       cmd_bytes,
   input  logic              sdb_req,
   input  logic [TAG_N-1:0]  sdb_tags,
   input  logic              sact_read,
   output logic [TAG_N-1:0]  done_tags,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              irq_d2h,
   output logic              irq_tfe,
   output logic              irq_sdb
);

   localparam int LEN_MAX = (D2H_LEN > SDB_LEN) ? D2H_LEN : SDB_LEN;
   localparam int IDX_W   = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

   if (TAG_N < 1 || TAG_N > 32) begin : g_bad_tags
      $error("rfis_writer: TAG_N must lie in 1..32");
   end
   if (D2H_LEN < 14) begin : g_bad_d2h
      $error("rfis_writer: D2H_LEN must cover bytes 0..13");
   end
   if (SDB_LEN < 8) begin : g_bad_sdb
      $error("rfis_writer: SDB_LEN must cover bytes 0..7");
   end

   logic gate;
   assign gate = rx_enable && area_valid;

   logic [TAG_N-1:0] mask;

   rfis_done_mask #(.TAG_N(TAG_N)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_en   (sdb_req && gate),
      .add_tags (sdb_tags),
      .clr      (sact_read),
      .mask     (mask)
   );
   assign done_tags = mask;

   logic                  a_sdb, a_g;
   logic [IDX_W-1:0]      idx;
   logic [7:0]            a_st, a_er;
   logic [CMD_ECHO_W-1:0] a_cmd;
   logic [TAG_N-1:0]      a_tags;
   logic                  we_c;
   logic [ADDR_W-1:0]     addr_c;
   logic [7:0]            data_c;
   logic                  d2h_c, tfe_c, sdb_c;

   rfis_seq #(
      .ADDR_W (ADDR_W), .TAG_N (TAG_N),
      .D2H_LEN(D2H_LEN), .SDB_LEN(SDB_LEN),
      .D2H_OFS(D2H_OFS), .SDB_OFS(SDB_OFS),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (gate),
      .d2h_req  (d2h_req),
      .d2h_init (d2h_init),
      .atapi    (atapi_dev),
      .cmd_img  (cmd_bytes),
      .st_in    (tf_status),
      .er_in    (tf_error),
      .gpend    (glob_irq_pend),
      .sdb_req  (sdb_req),
      .base_in  (area_base),
      .mask_now (mask),
      .a_sdb    (a_sdb),
      .idx      (idx),
      .a_st     (a_st),
      .a_er     (a_er),
      .a_g      (a_g),
      .a_cmd    (a_cmd),
      .a_tags   (a_tags),
      .we       (we_c),
      .addr     (addr_c),
      .p_d2h    (d2h_c),
      .p_tfe    (tfe_c),
      .p_sdb    (sdb_c)
   );

   rfis_frame_gen #(.TAG_N(TAG_N), .IDX_W(IDX_W)) u_gen (
      .is_sdb (a_sdb),
      .idx    (idx),
      .st     (a_st),
      .er     (a_er),
      .gflag  (a_g),
      .cmd    (a_cmd),
      .tags   (a_tags),
      .data   (data_c)
   );

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_we    <= 1'b0;
               mem_addr  <= '0;
               mem_wdata <= '0;
               irq_d2h   <= 1'b0;
               irq_tfe   <= 1'b0;
               irq_sdb   <= 1'b0;
            end else begin
               mem_we    <= we_c;
               mem_addr  <= addr_c;
               mem_wdata <= data_c;
               irq_d2h   <= d2h_c;
               irq_tfe   <= tfe_c;
               irq_sdb   <= sdb_c;
            end
         end
      end else begin : g_comb_out
         assign mem_we    = we_c;
         assign mem_addr  = addr_c;
         assign mem_wdata = data_c;
         assign irq_d2h   = d2h_c;
         assign irq_tfe   = tfe_c;
         assign irq_sdb   = sdb_c;
      end
   endgenerate

endmodule

// File: rtl/rfis_writer_chk.sv
module rfis_writer_chk #(
   parameter int ADDR_W = 32,
   parameter int TAG_N  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_enable,
   input logic              area_valid,
   input logic              sdb_req,
   input logic [TAG_N-1:0]  sdb_tags,
   input logic              sact_read,
   input logic [TAG_N-1:0]  done_tags,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              irq_d2h,
   input logic              irq_tfe,
   input logic              irq_sdb
);

   logic gate;
   assign gate = rx_enable && area_valid;

   p_gate_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sdb_req && !gate && !sact_read) |=> $stable(done_tags));

   p_accum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sdb_req && gate) |=> ((done_tags & $past(sdb_tags)) == $past(sdb_tags)));

   p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sact_read && !sdb_req) |=> (done_tags == '0));

   p_tfe_with_d2h_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tfe |-> irq_d2h);

   p_irq_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_d2h || irq_sdb) |-> $past(mem_we));

   p_irq_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_d2h, irq_sdb, mem_we}));

   p_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind rfis_writer rfis_writer_chk #(.ADDR_W(ADDR_W), .TAG_N(TAG_N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_enable  (rx_enable),
   .area_valid (area_valid),
   .sdb_req    (sdb_req),
   .sdb_tags   (sdb_tags),
   .sact_read  (sact_read),
   .done_tags  (done_tags),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .irq_d2h    (irq_d2h),
   .irq_tfe    (irq_tfe),
   .irq_sdb    (irq_sdb)
);

// File: tb/rfis_writer_tb_top.sv
module rfis_writer_tb_top;

   localparam int ADDR_W = 32;
   localparam int TAG_N  = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_enable = 1'b0;
   logic              area_valid = 1'b0;
   logic [ADDR_W-1:0] area_base = '0;
   logic [7:0]        tf_status = '0;
   logic [7:0]        tf_error = '0;
   logic              glob_irq_pend = 1'b0;
   logic              d2h_req = 1'b0;
   logic              d2h_init = 1'b0;
   logic              atapi_dev = 1'b0;
   logic [79:0]       cmd_bytes = '0;
   logic              sdb_req = 1'b0;
   logic [TAG_N-1:0]  sdb_tags = '0;
   logic              sact_read = 1'b0;
   logic [TAG_N-1:0]  done_tags;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic              irq_d2h, irq_tfe, irq_sdb;

   always #2 clk = ~clk;

   rfis_writer #(.ADDR_W(ADDR_W), .TAG_N(TAG_N)) dut_i (.*);

   int checks = 0;
   int fails  = 0;
   int stray  = 0;
   bit finished = 1'b0;

   logic [31:0] wq_a[$];
   logic [7:0]  wq_d[$];
   string       wq_r[$];
   logic [2:0]  iq_v[$];
   string       iq_r[$];
   logic [31:0] model_mask = '0;

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_we) begin
            if (wq_a.size() == 0) begin
               stray++; fails++;
               $display("FAIL R1 actual=write@%0h expected=none", mem_addr);
            end else begin
               logic [31:0] ea;
               logic [7:0]  ed;
               string       er;
               ea = wq_a.pop_front(); ed = wq_d.pop_front(); er = wq_r.pop_front();
               chk({er, " addr"}, 64'(mem_addr), 64'(ea));
               chk({er, " data"}, 64'(mem_wdata), 64'(ed));
            end
         end
         if (irq_d2h || irq_tfe || irq_sdb) begin
            if (iq_v.size() == 0) begin
               stray++; fails++;
               $display("FAIL R1 actual=irq%0b expected=none", {irq_tfe, irq_d2h, irq_sdb});
            end else begin
               logic [2:0] ev;
               string      er;
               ev = iq_v.pop_front(); er = iq_r.pop_front();
               chk({er, " irq"}, 64'({irq_tfe, irq_d2h, irq_sdb}), 64'(ev));
            end
         end
      end
   end

   function automatic logic [79:0] init_img(input logic atapi);
      logic [79:0] c = '0;
      c[7:0] = 8'h01; c[71:64] = 8'h01;
      if (atapi) begin c[15:8] = 8'h14; c[23:16] = 8'hEB; end
      return c;
   endfunction

   task automatic push_d2h(input logic [31:0] base, input logic [7:0] st, input logic [7:0] er,
                           input logic g, input logic [79:0] cmd, input string r);
      for (int i = 0; i < 32; i++) begin
         logic [7:0] b;
         if (i == 0)      b = 8'h34;
         else if (i == 1) b = g ? 8'h40 : 8'h00;
         else if (i == 2) b = st;
         else if (i == 3) b = er;
         else if (i < 14) b = cmd[8*(i-4) +: 8];
         else             b = 8'h00;
         wq_a.push_back(base + 32'h40 + 32'(i));
         wq_d.push_back(b);
         wq_r.push_back(r);
      end
      iq_v.push_back({st[0], 1'b1, 1'b0});
      iq_r.push_back({r, " R4"});
   endtask

   task automatic push_sdb(input logic [31:0] base, input logic [7:0] st, input logic [7:0] er,
                           input logic [31:0] tags, input string r);
      logic [7:0] b [8];
      model_mask = model_mask | tags;
      b[0] = er; b[1] = 8'h00; b[2] = st & 8'h77; b[3] = 8'h00;
      for (int k = 0; k < 4; k++) b[4+k] = model_mask[8*k +: 8];
      for (int i = 0; i < 8; i++) begin
         wq_a.push_back(base + 32'h58 + 32'(i));
         wq_d.push_back(b[i]);
         wq_r.push_back(r);
      end
      iq_v.push_back(3'b001);
      iq_r.push_back({r, " irq"});
   endtask

   task automatic drive_d2h(input logic init, input logic atapi, input logic [7:0] st,
                            input logic [7:0] er, input logic g, input logic [79:0] cmd);
      @(negedge clk);
      d2h_req = 1'b1; d2h_init = init; atapi_dev = atapi;
      tf_status = st; tf_error = er; glob_irq_pend = g; cmd_bytes = cmd;
      @(negedge clk);
      d2h_req = 1'b0; d2h_init = 1'b0; atapi_dev = 1'b0;
   endtask

   task automatic drive_sdb(input logic [7:0] st, input logic [7:0] er, input logic [31:0] tags);
      @(negedge clk);
      sdb_req = 1'b1; sdb_tags = tags; tf_status = st; tf_error = er;
      @(negedge clk);
      sdb_req = 1'b0; sdb_tags = '0;
   endtask

   task automatic drain();
      int n = 0;
      while ((wq_a.size() != 0 || iq_v.size() != 0) && n < 500) begin
         @(negedge clk); n++;
      end
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [79:0] pat(input logic [7:0] seed);
      logic [79:0] c;
      for (int k = 0; k < 10; k++) c[8*k +: 8] = seed + 8'(k * 17);
      return c;
   endfunction

   initial begin
      #400000;
      if (!finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] b0, b1;
      b0 = 32'h1000_0000;
      b1 = 32'h0000_2000;
      repeat (4) @(negedge clk);
      chk("R6 reset mask", 64'(done_tags), 64'h0);
      chk("R4 reset irq", 64'({irq_d2h, irq_tfe, irq_sdb, mem_we}), 64'h0);
      rst_n = 1'b1;
      rx_enable = 1'b1; area_valid = 1'b1; area_base = b0;

      // R2 R3 R4: plain register frame, no error
      push_d2h(b0, 8'h50, 8'h00, 1'b0, pat(8'hA0), "R2/R3 plain");
      drive_d2h(1'b0, 1'b0, 8'h50, 8'h00, 1'b0, pat(8'hA0));
      drain();
      // R2 R4: error bit and global pending flag
      push_d2h(b0, 8'h51, 8'h04, 1'b1, pat(8'h11), "R2/R4 err");
      drive_d2h(1'b0, 1'b0, 8'h51, 8'h04, 1'b1, pat(8'h11));
      drain();
      // R8: power-on images
      push_d2h(b0, 8'h50, 8'h01, 1'b0, init_img(1'b0), "R8 disk");
      drive_d2h(1'b1, 1'b0, 8'h50, 8'h01, 1'b0, pat(8'h33));
      drain();
      push_d2h(b0, 8'h41, 8'h01, 1'b0, init_img(1'b1), "R8 pkt");
      drive_d2h(1'b1, 1'b1, 8'h41, 8'h01, 1'b0, pat(8'h77));
      drain();
      // R5 R6: completion frames with accumulation
      push_sdb(b0, 8'hC9, 8'h02, 32'h0000_0005, "R5 sdb");
      drive_sdb(8'hC9, 8'h02, 32'h0000_0005);
      drain();
      push_sdb(b0, 8'h50, 8'h00, 32'h8000_0100, "R6 accum");
      drive_sdb(8'h50, 8'h00, 32'h8000_0100);
      drain();
      chk("R6 mask", 64'(done_tags), 64'(model_mask));
      // R7: software read
      @(negedge clk);
      sact_read = 1'b1;
      chk("R7 read value", 64'(done_tags), 64'h8000_0105);
      @(negedge clk);
      sact_read = 1'b0;
      model_mask = '0;
      chk("R7 cleared", 64'(done_tags), 64'h0);
      // R7: read and new completion together
      model_mask = 32'h0000_0030;
      @(negedge clk);
      sact_read = 1'b1; sdb_req = 1'b1; sdb_tags = 32'h0000_0030;
      tf_status = 8'h40; tf_error = 8'h00;
      @(negedge clk);
      sact_read = 1'b0; sdb_req = 1'b0; sdb_tags = '0;
      chk("R7 same-cycle tags kept", 64'(done_tags), 64'h30);
      model_mask = '0;
      push_sdb(b0, 8'h40, 8'h00, 32'h0000_0030, "R7 sdb");
      drain();
      // R9: both requests in one cycle, new base
      area_base = b1;
      push_d2h(b1, 8'h58, 8'h00, 1'b0, pat(8'h5A), "R9 first");
      push_sdb(b1, 8'h58, 8'h00, 32'h0000_0200, "R9 second");
      @(negedge clk);
      d2h_req = 1'b1; sdb_req = 1'b1; sdb_tags = 32'h0000_0200;
      tf_status = 8'h58; tf_error = 8'h00; glob_irq_pend = 1'b0; cmd_bytes = pat(8'h5A);
      @(negedge clk);
      d2h_req = 1'b0; sdb_req = 1'b0; sdb_tags = '0;
      drain();
      // R9 R10: completion arrives mid register frame
      push_d2h(b1, 8'h50, 8'h00, 1'b1, pat(8'hC3), "R10 d2h");
      drive_d2h(1'b0, 1'b0, 8'h50, 8'h00, 1'b1, pat(8'hC3));
      repeat (5) @(negedge clk);
      push_sdb(b1, 8'hFF, 8'h10, 32'h0001_0000, "R9 queued sdb");
      drive_sdb(8'hFF, 8'h10, 32'h0001_0000);
      drain();
      // R1: reception disabled, then base not set
      rx_enable = 1'b0;
      drive_d2h(1'b0, 1'b0, 8'h51, 8'h00, 1'b0, pat(8'h01));
      drive_sdb(8'h50, 8'h00, 32'h0000_0F00);
      repeat (60) @(negedge clk);
      chk("R1 disabled mask", 64'(done_tags), 64'(model_mask));
      rx_enable = 1'b1; area_valid = 1'b0;
      drive_d2h(1'b0, 1'b0, 8'h51, 8'h00, 1'b0, pat(8'h02));
      drive_sdb(8'h50, 8'h00, 32'h0000_F000);
      repeat (60) @(negedge clk);
      chk("R1 no base mask", 64'(done_tags), 64'(model_mask));
      chk("R1 stray events", 64'(stray), 64'h0);
      chk("R9 queues drained", 64'(wq_a.size() + iq_v.size()), 64'h0);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule